// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block keeps a small, fully associative set of recent virtual-page to physical-page translations, so that an address translator can skip the page table walk whenever the wanted page is already held. Pages are 4 KB: the low twelve bits of an address pass straight through, and the upper virtual bits form the page number that is matched. Each entry also records the process context identifier that was current when it was written.

The translator presents a virtual address on the lookup port and gets hit, physical address and two permission flags (present, writable) back combinationally in the same cycle. After a walk it writes the result through the fill port. On a process change it pulses the switch input with the incoming process's root value and context identifier. With context tagging off, a switch empties the whole cache. With tagging on, entries survive and a hit also requires the stored identifier to equal the current one. Replacement takes a free entry first and otherwise rotates round-robin; a fill for a page already held overwrites that entry.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, the current root value and context identifier read zero and every lookup misses.
- R2: A lookup with `lkp_valid` high reports, in the same cycle, a hit when a valid entry's page number equals `lkp_vaddr[47:12]` (and, with `tag_en` high, its context equals `cur_ctx`); `lkp_paddr` is then {stored frame, `lkp_vaddr[11:0]`} and the flags are the stored ones. On a miss `lkp_paddr`, `lkp_present` and `lkp_writable` are zero.
- R3: A fill is written at the clock edge, tagged with `cur_ctx`; a lookup in the fill's own cycle still sees the old contents, and the entry hits from the next cycle.
- R4: A fill whose page number (and, with `tag_en` high, context) equals a valid entry's overwrites that entry, so no key is ever held twice.
- R5: A fill that matches no entry goes to the lowest-numbered invalid entry.
- R6: A fill that matches nothing while all entries are valid replaces the entry at a round-robin pointer, which then steps by one modulo the entry count; the pointer is zero after reset and moves only on such a replacement.
- R7: A switch pulse loads `sw_root` and `sw_ctx` into `cur_root` and `cur_ctx` at the clock edge.
- R8: A switch with `tag_en` low invalidates every entry; a fill in the same cycle is discarded.
- R9: A switch with `tag_en` high keeps all entries; entries written under another context miss and become hits again when their context returns. `tag_en` changes only in a cycle that carries a switch.
- R10: A lookup in the same cycle as an invalidating switch reports a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_en | input | 1 | 1 = entries tagged by context, 0 = switch invalidates all |
| lkp_valid | input | 1 | Lookup request |
| lkp_vaddr | input | 48 | Virtual address to translate |
| lkp_hit | output | 1 | Translation found |
| lkp_paddr | output | 52 | Physical address on hit |
| lkp_present | output | 1 | Stored present flag on hit |
| lkp_writable | output | 1 | Stored writable flag on hit |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 36 | Virtual page number of the fill |
| fill_pfn | input | 40 | Physical frame number of the fill |
| fill_present | input | 1 | Present flag of the fill |
| fill_writable | input | 1 | Writable flag of the fill |
| sw_valid | input | 1 | Context switch pulse |
| sw_root | input | 40 | Root value of the incoming process |
| sw_ctx | input | 12 | Context identifier of the incoming process |
| cur_root | output | 40 | Current root value |
| cur_ctx | output | 12 | Current context identifier |

## Verification
The functions that collide are lookup against context switch, and fill against lookup or switch. The bench drives a lookup of a page known to be held in the very cycle an untagged switch is pulsed and expects a miss, and drives a fill of a new page together with a lookup of that page, expecting a miss then a hit one cycle later. A fill raised together with an untagged switch is judged by looking the page up afterwards and expecting a miss.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  typedef enum logic [1:0] {
    SLOT_MATCH = 2'd0,
    SLOT_FREE  = 2'd1,
    SLOT_RR    = 2'd2
  } slot_src_e;
endpackage

// File: rtl/ctx_tlb_cmp.sv
module ctx_tlb_cmp #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int CTX_W   = 12
) (
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
  input  logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx,
  input  logic [VPN_W-1:0]              key_vpn,
  input  logic [CTX_W-1:0]              key_ctx,
  input  logic                          use_ctx,
  output logic [ENTRIES-1:0]            match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                      (!use_ctx || (ent_ctx[g] == key_ctx));
  end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0]     ent_valid,
  input  logic [ENTRIES-1:0]     fill_match,
  input  logic [IDX_W-1:0]       rr_ptr,
  output logic [IDX_W-1:0]       slot,
  output ctx_tlb_pkg::slot_src_e src
);
  import ctx_tlb_pkg::*;

  // Scanning downwards lets the lowest index win; a match outranks a free slot.
  always_comb begin
    slot = rr_ptr;
    src  = SLOT_RR;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        slot = IDX_W'(i);
        src  = SLOT_FREE;
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_match[i]) begin
        slot = IDX_W'(i);
        src  = SLOT_MATCH;
      end
    end
  end
endmodule

// File: rtl/ctx_tlb_ctx_reg.sv
module ctx_tlb_ctx_reg #(
  parameter int ROOT_W = 40,
  parameter int CTX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_valid,
  input  logic [ROOT_W-1:0] sw_root,
  input  logic [CTX_W-1:0]  sw_ctx,
  output logic [ROOT_W-1:0] cur_root,
  output logic [CTX_W-1:0]  cur_ctx
);
  logic [ROOT_W-1:0] root_d;
  logic [CTX_W-1:0]  ctx_d;

  always_comb begin
    root_d = cur_root;
    ctx_d  = cur_ctx;
    if (sw_valid) begin
      root_d = sw_root;
      ctx_d  = sw_ctx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_root <= '0;
      cur_ctx  <= '0;
    end else begin
      cur_root <= root_d;
      cur_ctx  <= ctx_d;
    end
  end

  assert_ctx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |=> (cur_root == $past(sw_root)) && (cur_ctx == $past(sw_ctx)));
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 48,
  parameter int PA_W      = 52,
  parameter int PAGE_BITS = 12,
  parameter int CTX_W     = 12,
  parameter int ROOT_W    = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tag_en,
  input  logic                          lkp_valid,
  input  logic [VA_W-1:0]               lkp_vaddr,
  output logic                          lkp_hit,
  output logic [PA_W-1:0]               lkp_paddr,
  output logic                          lkp_present,
  output logic                          lkp_writable,
  input  logic                          fill_valid,
  input  logic [VA_W-PAGE_BITS-1:0]     fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0]     fill_pfn,
  input  logic                          fill_present,
  input  logic                          fill_writable,
  input  logic                          sw_valid,
  input  logic [ROOT_W-1:0]             sw_root,
  input  logic [CTX_W-1:0]              sw_ctx,
  output logic [ROOT_W-1:0]             cur_root,
  output logic [CTX_W-1:0]              cur_ctx
);
  import ctx_tlb_pkg::*;

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][CTX_W-1:0] ctx_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0]            pres_q;
  logic [ENTRIES-1:0]            wr_q;
  logic [IDX_W-1:0]              rr_q, rr_d;

  logic                          flush;
  logic                          fill_go;
  logic [ENTRIES-1:0]            lkp_raw;
  logic [ENTRIES-1:0]            lkp_match;
  logic [ENTRIES-1:0]            fill_match;
  logic [IDX_W-1:0]              slot;
  slot_src_e                     slot_src;
  logic [ENTRIES-1:0]            wr_en;
  logic [PFN_W-1:0]              pfn_sel;

  assign flush   = sw_valid && !tag_en;
  assign fill_go = fill_valid && !flush;

  ctx_tlb_ctx_reg #(.ROOT_W(ROOT_W), .CTX_W(CTX_W)) ctx_reg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_valid (sw_valid),
    .sw_root  (sw_root),
    .sw_ctx   (sw_ctx),
    .cur_root (cur_root),
    .cur_ctx  (cur_ctx)
  );

  ctx_tlb_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) lkp_cmp_i (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .ent_ctx   (ctx_q),
    .key_vpn   (lkp_vaddr[VA_W-1:PAGE_BITS]),
    .key_ctx   (cur_ctx),
    .use_ctx   (tag_en),
    .match     (lkp_raw)
  );

  ctx_tlb_cmp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) fill_cmp_i (
    .ent_valid (valid_q),
    .ent_vpn   (vpn_q),
    .ent_ctx   (ctx_q),
    .key_vpn   (fill_vpn),
    .key_ctx   (cur_ctx),
    .use_ctx   (tag_en),
    .match     (fill_match)
  );

  ctx_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) victim_i (
    .ent_valid  (valid_q),
    .fill_match (fill_match),
    .rr_ptr     (rr_q),
    .slot       (slot),
    .src        (slot_src)
  );

  // Lookup result: an invalidating switch in this cycle wins over any hit.
  assign lkp_match = lkp_raw & {ENTRIES{lkp_valid && !flush}};

  always_comb begin
    lkp_hit      = 1'b0;
    pfn_sel      = '0;
    lkp_present  = 1'b0;
    lkp_writable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_match[i]) begin
        lkp_hit      = 1'b1;
        pfn_sel      = pfn_sel | pfn_q[i];
        lkp_present  = lkp_present | pres_q[i];
        lkp_writable = lkp_writable | wr_q[i];
      end
    end
  end

  assign lkp_paddr = lkp_hit ? {pfn_sel, lkp_vaddr[PAGE_BITS-1:0]} : '0;

  // Next state of valid bits and round-robin pointer.
  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    if (flush) begin
      valid_d = '0;
    end else if (fill_go) begin
      valid_d[slot] = 1'b1;
      if (slot_src == SLOT_RR) begin
        rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  // Entry payload: no reset needed, qualified by the valid bits.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_en[g] = fill_go && (slot == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        vpn_q[g]  <= fill_vpn;
        ctx_q[g]  <= cur_ctx;
        pfn_q[g]  <= fill_pfn;
        pres_q[g] <= fill_present;
        wr_q[g]   <= fill_writable;
      end
    end
  end

  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lkp_raw));

  assert_free_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && (slot_src == SLOT_RR)) |-> (&valid_q));

  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> valid_q[$past(slot)]);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  assert_flush_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && flush) |-> !lkp_hit);

  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_hit |-> ((lkp_paddr == '0) && !lkp_present && !lkp_writable));
endmodule

// File: tb/ctx_tlb_tb_top.sv
module ctx_tlb_tb_top;
  localparam int E = 4;

  logic        clk, rst_n, tag_en;
  logic        lkp_valid;
  logic [47:0] lkp_vaddr;
  logic        lkp_hit, lkp_present, lkp_writable;
  logic [51:0] lkp_paddr;
  logic        fill_valid, fill_present, fill_writable;
  logic [35:0] fill_vpn;
  logic [39:0] fill_pfn;
  logic        sw_valid;
  logic [39:0] sw_root, cur_root;
  logic [11:0] sw_ctx, cur_ctx;

  int n_checks = 0;
  int n_errors = 0;

  // Bench model of the cache.
  bit          m_v   [E];
  logic [35:0] m_vpn [E];
  logic [11:0] m_ctx [E];
  logic [39:0] m_pfn [E];
  bit          m_p   [E];
  bit          m_w   [E];
  int          m_ptr;
  logic [11:0] m_cur;
  bit          m_tag;

  logic [35:0] used [64];
  int          n_used = 0;

  ctx_tlb #(.ENTRIES(E)) dut_i (
    .clk(clk), .rst_n(rst_n), .tag_en(tag_en),
    .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr), .lkp_hit(lkp_hit),
    .lkp_paddr(lkp_paddr), .lkp_present(lkp_present), .lkp_writable(lkp_writable),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_present(fill_present), .fill_writable(fill_writable),
    .sw_valid(sw_valid), .sw_root(sw_root), .sw_ctx(sw_ctx),
    .cur_root(cur_root), .cur_ctx(cur_ctx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic note_vpn(input logic [35:0] vpn);
    for (int i = 0; i < n_used; i++) if (used[i] == vpn) return;
    if (n_used < 64) begin
      used[n_used] = vpn;
      n_used++;
    end
  endtask

  task automatic model_fill(input logic [35:0] vpn, input logic [39:0] pfn,
                            input bit p, input bit w);
    int s = -1;
    for (int i = 0; i < E; i++)
      if (s < 0 && m_v[i] && m_vpn[i] == vpn && (!m_tag || m_ctx[i] == m_cur)) s = i;
    if (s < 0)
      for (int i = 0; i < E; i++) if (s < 0 && !m_v[i]) s = i;
    if (s < 0) begin
      s = m_ptr;
      m_ptr = (m_ptr + 1) % E;
    end
    m_v[s] = 1; m_vpn[s] = vpn; m_ctx[s] = m_cur;
    m_pfn[s] = pfn; m_p[s] = p; m_w[s] = w;
  endtask

  task automatic do_fill(input logic [35:0] vpn, input logic [39:0] pfn,
                         input bit p, input bit w);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn;
    fill_present = p; fill_writable = w;
    @(posedge clk);
    model_fill(vpn, pfn, p, w);
    note_vpn(vpn);
    #1 fill_valid = 0;
  endtask

  task automatic do_switch(input logic [39:0] root, input logic [11:0] ctx,
                           input bit ten);
    @(negedge clk);
    sw_valid = 1; sw_root = root; sw_ctx = ctx; tag_en = ten;
    @(posedge clk);
    m_tag = ten;
    if (!ten) for (int i = 0; i < E; i++) m_v[i] = 0;
    m_cur = ctx;
    #1 sw_valid = 0;
    @(negedge clk);
    chk(cur_root == root, "R7 root", 64'(cur_root), 64'(root));
    chk(cur_ctx == ctx, "R7 ctx", 64'(cur_ctx), 64'(ctx));
  endtask

  task automatic expect_lookup(input logic [47:0] va, input string req);
    bit          e_hit = 0;
    logic [51:0] e_pa = '0;
    bit          e_p = 0, e_w = 0;
    for (int i = 0; i < E; i++)
      if (m_v[i] && m_vpn[i] == va[47:12] && (!m_tag || m_ctx[i] == m_cur)) begin
        e_hit = 1; e_pa = {m_pfn[i], va[11:0]}; e_p = m_p[i]; e_w = m_w[i];
      end
    @(negedge clk);
    lkp_valid = 1; lkp_vaddr = va;
    #1;
    chk(lkp_hit == e_hit, {req, " hit"}, 64'(lkp_hit), 64'(e_hit));
    chk(lkp_paddr == e_pa, {req, " paddr"}, 64'(lkp_paddr), 64'(e_pa));
    chk({lkp_present, lkp_writable} == {e_p, e_w}, {req, " flags"},
        64'({lkp_present, lkp_writable}), 64'({e_p, e_w}));
    lkp_valid = 0;
  endtask

  task automatic sweep(input string req, input logic [11:0] off);
    for (int i = 0; i < n_used; i++) expect_lookup({used[i], off}, req);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 0; tag_en = 0; lkp_valid = 0; lkp_vaddr = '0;
    fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_present = 0; fill_writable = 0;
    sw_valid = 0; sw_root = '0; sw_ctx = '0;
    for (int i = 0; i < E; i++) m_v[i] = 0;
    m_ptr = 0; m_cur = '0; m_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk(cur_root == '0, "R1 root", 64'(cur_root), 0);
    chk(cur_ctx == '0, "R1 ctx", 64'(cur_ctx), 0);
    expect_lookup(48'h0, "R1");
    expect_lookup(48'h0000_0010_0abc, "R1");

    // R2/R5: fill free entries, sweep offsets
    for (int i = 0; i < E; i++)
      do_fill(36'h100 + 36'(i), 40'hA0000 + 40'(i * 7), 1'b1, i[0]);
    sweep("R2 off0", 12'h000);
    sweep("R2 offfff", 12'hfff);
    sweep("R5 off5a5", 12'h5a5);

    // R6: round-robin replacement over two full turns
    for (int i = 0; i < 2 * E + 1; i++) begin
      do_fill(36'h200 + 36'(i), 40'hB0000 + 40'(i * 3), i[1], 1'b1);
      sweep("R6", 12'(i * 'h111));
    end

    // R4: overwrite a held page
    for (int i = 0; i < E; i++) begin
      if (m_v[i]) begin
        do_fill(m_vpn[i], 40'hC0000 + 40'(i), 1'b0, 1'b1);
        sweep("R4", 12'h321);
      end
    end

    // R3: lookup in the fill's own cycle sees old contents
    @(negedge clk);
    fill_valid = 1; fill_vpn = 36'h777; fill_pfn = 40'hD7777;
    fill_present = 1; fill_writable = 0;
    lkp_valid = 1; lkp_vaddr = {36'h777, 12'h123};
    #1;
    chk(lkp_hit == 0, "R3 same cycle", 64'(lkp_hit), 0);
    @(posedge clk);
    model_fill(36'h777, 40'hD7777, 1'b1, 1'b0);
    note_vpn(36'h777);
    #1 fill_valid = 0; lkp_valid = 0;
    expect_lookup({36'h777, 12'h123}, "R3 next cycle");

    // R8: untagged switch empties the cache
    do_switch(40'h12345, 12'h005, 1'b0);
    sweep("R8", 12'h0ff);

    // R8: fill with untagged switch is discarded
    @(negedge clk);
    fill_valid = 1; fill_vpn = 36'h888; fill_pfn = 40'hE8888;
    sw_valid = 1; sw_root = 40'h2; sw_ctx = 12'h6; tag_en = 0;
    @(posedge clk);
    m_cur = 12'h6;
    note_vpn(36'h888);
    #1 fill_valid = 0; sw_valid = 0;
    expect_lookup({36'h888, 12'h0}, "R8 fill dropped");

    // R10: lookup coinciding with invalidating switch misses
    do_fill(36'h300, 40'hF0300, 1'b1, 1'b1);
    expect_lookup({36'h300, 12'h010}, "R10 before");
    @(negedge clk);
    sw_valid = 1; sw_root = 40'h3; sw_ctx = 12'h7; tag_en = 0;
    lkp_valid = 1; lkp_vaddr = {36'h300, 12'h010};
    #1;
    chk(lkp_hit == 0, "R10 same cycle", 64'(lkp_hit), 0);
    chk(lkp_paddr == '0, "R10 paddr", 64'(lkp_paddr), 0);
    @(posedge clk);
    for (int i = 0; i < E; i++) m_v[i] = 0;
    m_cur = 12'h7;
    #1 sw_valid = 0; lkp_valid = 0;
    expect_lookup({36'h300, 12'h010}, "R10 after");

    // R9: tagged contexts
    do_switch(40'hA1, 12'h001, 1'b1);
    do_fill(36'h400, 40'h11111, 1'b1, 1'b0);
    do_fill(36'h401, 40'h11112, 1'b1, 1'b1);
    do_switch(40'hA2, 12'h002, 1'b1);
    expect_lookup({36'h400, 12'h044}, "R9 other ctx miss");
    do_fill(36'h400, 40'h22222, 1'b0, 1'b1);
    expect_lookup({36'h400, 12'h044}, "R9 own ctx hit");
    do_switch(40'hA1, 12'h001, 1'b1);
    expect_lookup({36'h400, 12'h044}, "R9 ctx return");
    expect_lookup({36'h401, 12'hfff}, "R9 ctx return 2");
    for (int i = 0; i < E + 2; i++) begin
      do_fill(36'h500 + 36'(i), 40'h33000 + 40'(i), 1'b1, i[0]);
      sweep("R9 rr", 12'h00c);
    end
    do_switch(40'hA2, 12'h002, 1'b1);
    sweep("R9 ctx2", 12'h00c);

    // Return to untagged mode with a flush
    do_switch(40'h0, 12'h000, 1'b0);
    sweep("R8 final", 12'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule